// File: doc/BRIEF.md
# Unary Register Operation Unit

This block holds the working registers of a small 16-bit accumulator machine (an accumulator, an index register and a four-bit condition register) and carries out that machine's single-byte register instructions. A sequencer presents an 8-bit operation code together with a valid strobe. The unit decodes the code, updates the chosen register and the condition bits at the next clock edge, and raises a one-cycle completion pulse at the same time.

The lowest opcode bit selects the target of the bit and shift operations: the accumulator or the index register. Three further codes copy the externally held stack pointer into the accumulator, place the condition bits into the accumulator's low nibble, and load the condition bits back from that nibble. A code that is not one of these is rejected. No state changes, and an error pulse is raised instead of the completion pulse.

Top module: `urx_unit`

## Requirements
- R1: After reset the accumulator, the index register and the condition bits are all zero, and neither `opDone` nor `opIllegal` is asserted.
- R2: For codes 0x06 to 0x11, opcode bit 0 selects the target: 0 writes the accumulator and 1 writes the index register. The register that is not selected keeps its value.
- R3: Codes 0x06/0x07 replace the target with its bitwise complement. N takes the result's bit 15, Z is set when the result is zero, and V and C keep their values.
- R4: Codes 0x08/0x09 replace the target with its two's complement and update N and Z. V is set only when the operand was 0x8000, and C keeps its value.
- R5: Codes 0x0A/0x0B shift the target left by one and insert a zero. C takes the old bit 15, V is set when old bits 15 and 14 differ, and N and Z follow the result.
- R6: Codes 0x0C/0x0D shift the target right by one and copy bit 15 into itself. C takes the old bit 0, N and Z follow the result, and V keeps its value.
- R7: Codes 0x0E/0x0F rotate the target left through C, and codes 0x10/0x11 rotate it right through C. The old C fills the vacated bit, the bit shifted out becomes the new C, and N, Z and V keep their values.
- R8: Code 0x03 copies the `stackPtr` input into the accumulator and leaves the condition bits unchanged.
- R9: Code 0x04 writes the accumulator as {12'b0, N, Z, V, C}, with C in bit 0.
- R10: Code 0x05 loads N, Z, V and C from accumulator bits 3, 2, 1 and 0. The registers are unchanged.
- R11: A legal code sampled with `opValid` high produces its register and flag result and a one-cycle `opDone` at the following clock edge. Codes may arrive back to back on consecutive cycles, and each code sees the results of the one before it.
- R12: Any other code (0x00 to 0x02 and 0x12 to 0xFF) leaves all state unchanged and gives one cycle of `opIllegal` in place of `opDone`.
- R13: While `opValid` is low, the registers and flags hold, and neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation code strobe |
| opCode | input | 8 | Single-byte operation code |
| stackPtr | input | 16 | Current stack pointer value |
| accOut | output | 16 | Accumulator |
| idxOut | output | 16 | Index register |
| flagsOut | output | 4 | Condition bits {N, Z, V, C} |
| opDone | output | 1 | One-cycle pulse after a legal operation |
| opIllegal | output | 1 | One-cycle pulse after an unknown code |

## Verification
Two things can fall in the same clock edge: a register write and a condition-bit write that depends on the same operand. Rotate-through-carry and the flag-nibble moves make this plain, because the old C must enter the data while the data's outgoing bit becomes the new C. The bench provokes this with codes issued back to back on consecutive cycles, so that each rotate or flag move reads the C or accumulator value written one edge earlier. A bench model, advanced in step with the design, judges every cycle: all of the register, flag and pulse outputs are compared against it.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_NOT,
    OP_NEG,
    OP_ASL,
    OP_ASR,
    OP_ROL,
    OP_ROR,
    OP_SPA,
    OP_FLGA,
    OP_AFLG
  } urxOp_e;

  typedef struct packed {
    urxOp_e op;
    logic   selIdx;
    logic   writeReg;
    logic   writeFlags;
  } urxStrobe_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

endpackage

// File: rtl/urx_ctrl.sv
module urx_ctrl
  import urx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opCode,
  output urxStrobe_t stb,
  output logic       opDone,
  output logic       opIllegal
);

  logic legal;

  always_comb begin
    stb = '{op: OP_NONE, selIdx: 1'b0, writeReg: 1'b0, writeFlags: 1'b0};
    legal = 1'b1;
    unique case (opCode[7:1])
      7'b0000_011: stb.op = OP_NOT;
      7'b0000_100: stb.op = OP_NEG;
      7'b0000_101: stb.op = OP_ASL;
      7'b0000_110: stb.op = OP_ASR;
      7'b0000_111: stb.op = OP_ROL;
      7'b0001_000: stb.op = OP_ROR;
      7'b0000_001: stb.op = opCode[0] ? OP_SPA  : OP_NONE;
      7'b0000_010: stb.op = opCode[0] ? OP_AFLG : OP_FLGA;
      default:     stb.op = OP_NONE;
    endcase
    if (stb.op == OP_NONE) legal = 1'b0;
    if (!opValid || !legal) begin
      stb.op = OP_NONE;
    end else begin
      unique case (stb.op)
        OP_SPA:  stb.writeReg = 1'b1;
        OP_FLGA: stb.writeReg = 1'b1;
        OP_AFLG: stb.writeFlags = 1'b1;
        default: begin
          stb.selIdx     = opCode[0];
          stb.writeReg   = 1'b1;
          stb.writeFlags = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opDone    <= 1'b0;
      opIllegal <= 1'b0;
    end else begin
      opDone    <= opValid && legal;
      opIllegal <= opValid && !legal;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(opDone && opIllegal));  // R12
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !opDone && !opIllegal);  // R13

endmodule

// File: rtl/urx_datapath.sv
module urx_datapath
  import urx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  urxStrobe_t        stb,
  input  logic [DATA_W-1:0] stackPtr,
  output logic [DATA_W-1:0] accQ,
  output logic [DATA_W-1:0] idxQ,
  output logic [3:0]        flagsQ
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] result;
  logic [3:0]        nextFlags;
  logic              oldC;

  assign operand = stb.selIdx ? idxQ : accQ;
  assign oldC    = flagsQ[FLAG_C];

  always_comb begin
    result    = operand;
    nextFlags = flagsQ;
    unique case (stb.op)
      OP_NOT: result = ~operand;
      OP_NEG: begin
        result = -operand;
        nextFlags[FLAG_V] = (operand == MIN_NEG);
      end
      OP_ASL: begin
        result = {operand[MSB-1:0], 1'b0};
        nextFlags[FLAG_C] = operand[MSB];
        nextFlags[FLAG_V] = operand[MSB] ^ operand[MSB-1];
      end
      OP_ASR: begin
        result = {operand[MSB], operand[MSB:1]};
        nextFlags[FLAG_C] = operand[0];
      end
      OP_ROL: begin
        result = {operand[MSB-1:0], oldC};
        nextFlags[FLAG_C] = operand[MSB];
      end
      OP_ROR: begin
        result = {oldC, operand[MSB:1]};
        nextFlags[FLAG_C] = operand[0];
      end
      OP_SPA:  result = stackPtr;
      OP_FLGA: result = {{(DATA_W-4){1'b0}}, flagsQ};
      OP_AFLG: nextFlags = accQ[3:0];
      default: ;
    endcase
    if (stb.op inside {OP_NOT, OP_NEG, OP_ASL, OP_ASR}) begin
      nextFlags[FLAG_N] = result[MSB];
      nextFlags[FLAG_Z] = (result == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      idxQ   <= '0;
      flagsQ <= '0;
    end else begin
      if (stb.writeReg && !stb.selIdx) accQ <= result;
      if (stb.writeReg && stb.selIdx)  idxQ <= result;
      if (stb.writeFlags)              flagsQ <= nextFlags;
    end
  end

  AST_OTHER_REG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeReg && stb.selIdx) |=> $stable(accQ));  // R2
  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.op == OP_ROL && !stb.selIdx) |=>
      accQ[0] == $past(flagsQ[FLAG_C]) && flagsQ[FLAG_C] == $past(accQ[MSB]));  // R7
  AST_ROR_KEEPS_NZV: assert property (@(posedge clk) disable iff (!rstN)
    (stb.op == OP_ROR) |=> flagsQ[3:1] == $past(flagsQ[3:1]));  // R7
  AST_SPA_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.op == OP_SPA) |=> $stable(flagsQ) && accQ == $past(stackPtr));  // R8

endmodule

// File: rtl/urx_unit.sv
module urx_unit
  import urx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opCode,
  input  logic [DATA_W-1:0] stackPtr,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] idxOut,
  output logic [3:0]        flagsOut,
  output logic              opDone,
  output logic              opIllegal
);

  urxStrobe_t stb;

  urx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .stb      (stb),
    .opDone   (opDone),
    .opIllegal(opIllegal)
  );

  urx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .stackPtr(stackPtr),
    .accQ    (accOut),
    .idxQ    (idxOut),
    .flagsQ  (flagsOut)
  );

  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    opIllegal |-> $stable(accOut) && $stable(idxOut) && $stable(flagsOut));  // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(accOut) && $stable(idxOut) && $stable(flagsOut));  // R13
  AST_FLAG_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 8'h05) |=> flagsOut == $past(accOut[3:0]));  // R10

endmodule

// File: tb/urx_unit_bench.sv
module urx_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opCode = 8'h00;
  logic [15:0] stackPtr = 16'h0000;
  logic [15:0] accOut, idxOut;
  logic [3:0]  flagsOut;
  logic        opDone, opIllegal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mA = 0, mX = 0;
  logic [3:0]  mF = 0;

  always #2.5 clk = ~clk;

  urx_unit u_urx_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .stackPtr(stackPtr), .accOut(accOut), .idxOut(idxOut),
    .flagsOut(flagsOut), .opDone(opDone), .opIllegal(opIllegal)
  );

  function automatic string reqOf(input logic v, input logic [7:0] c);
    if (!v) return "R13";
    case (c)
      8'h03: return "R8";
      8'h04: return "R9";
      8'h05: return "R10";
      8'h06, 8'h07: return "R3";
      8'h08, 8'h09: return "R4";
      8'h0A, 8'h0B: return "R5";
      8'h0C, 8'h0D: return "R6";
      8'h0E, 8'h0F, 8'h10, 8'h11: return "R7";
      default: return "R12";
    endcase
  endfunction

  function automatic logic legalOf(input logic [7:0] c);
    return (c >= 8'h03) && (c <= 8'h11);
  endfunction

  // Reference: advance the model by one operation
  task automatic modelStep(input logic v, input logic [7:0] c, input logic [15:0] sp);
    logic [15:0] t, r;
    logic n, z, vv, cy;
    if (!v || !legalOf(c)) return;
    {n, z, vv, cy} = mF;
    if (c == 8'h03) begin mA = sp; return; end
    if (c == 8'h04) begin mA = 16'(mF); return; end
    if (c == 8'h05) begin mF = mA[3:0]; return; end
    t = c[0] ? mX : mA;
    case (c[7:1])
      7'h03: begin r = 16'hFFFF - t; n = r[15]; z = (r == 0); end
      7'h04: begin r = 16'h0000 - t; vv = (t == 16'h8000); n = r[15]; z = (r == 0); end
      7'h05: begin r = t * 2; cy = t[15]; vv = (t[15] != t[14]); n = r[15]; z = (r == 0); end
      7'h06: begin r = (t / 2) | (t & 16'h8000); cy = t[0]; n = r[15]; z = (r == 0); end
      7'h07: begin r = (t * 2) | 16'(cy); cy = t[15]; end
      default: begin r = (t / 2) | (cy ? 16'h8000 : 16'h0); cy = t[0]; end
    endcase
    mF = {n, z, vv, cy};
    if (c[0]) mX = r; else mA = r;
  endtask

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic step(input logic v, input logic [7:0] c, input logic [15:0] sp);
    string req;
    logic legal;
    req = reqOf(v, c);
    legal = legalOf(c);
    opValid = v; opCode = c; stackPtr = sp;
    modelStep(v, c, sp);
    @(negedge clk);
    check(req, "acc", accOut, mA);
    check((v && legal && c[0] && c >= 8'h06) ? "R2" : req, "idx", idxOut, mX);
    check(req, "flags", 16'(flagsOut), 16'(mF));
    check((v && legal) ? "R11" : req, "done", 16'(opDone), 16'(v && legal));
    check(req, "illegal", 16'(opIllegal), 16'(v && !legal));
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "acc", accOut, 16'h0);
    check("R1", "idx", idxOut, 16'h0);
    check("R1", "flags", 16'(flagsOut), 16'h0);
    check("R1", "pulses", {14'h0, opDone, opIllegal}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    step(1, 8'h03, 16'h8000);   // R8 load 0x8000
    step(1, 8'h08, 16'h1111);   // R4 negate min -> V set
    step(1, 8'h04, 16'h0);      // R9 flags to acc
    step(1, 8'h0A, 16'h0);      // R5 shift
    step(1, 8'h03, 16'h4001);
    step(1, 8'h0A, 16'h0);      // R5 sign change sets V
    step(1, 8'h0C, 16'h0);      // R6 sign replicate
    step(1, 8'h03, 16'h000A);
    step(1, 8'h05, 16'h0);      // R10 flags from nibble 1010
    step(1, 8'h0E, 16'h0);      // R7 rotate with C=0
    step(1, 8'h07, 16'h0);      // R3 invert X
    step(1, 8'h11, 16'h0);      // R7 rotate X right, C from X
    step(1, 8'h0E, 16'h0);      // R7 back to back: uses C just written
    step(1, 8'h04, 16'h0);      // R9 immediately after
    step(1, 8'h02, 16'h0);      // R12 just below range
    step(1, 8'h12, 16'h0);      // R12 just above range
    step(0, 8'h06, 16'h0);      // R13 strobe low
    step(1, 8'h09, 16'h0);      // R4 negate X
    step(1, 8'h0D, 16'h0);      // R6 on X

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic [7:0] c;
      int pick;
      v = ($urandom_range(0, 9) != 0);
      pick = $urandom_range(0, 9);
      if (pick < 7) c = 8'($urandom_range(3, 17));
      else c = 8'($urandom);
      step(v, c, 16'($urandom));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule